// File: doc/BRIEF.md
# ADC Conversion Timing Tick Generator

This block runs on a fast parent clock and derives three enable pulses that pace an ADC controller: a main conversion enable, a slower tick meant for roughly 10 µs intervals, and a slower still tick meant for roughly 1 ms intervals. The two slow ticks do not count parent cycles. Each one counts main enables, so both slow periods scale with the main divisor.

All three ratios sit in one 32-bit configuration word that is loaded through a single-cycle write port. Each field holds its ratio minus one. Every output is a pulse one parent cycle wide. A write restarts all three counters, so the first period after a change is a full one at the new ratio.

Top module: `adc_tick_gen`

## Requirements
- R1: After reset the configuration word reads as zero. All three ratios are then 1, so every tick output is high on every cycle that has no write.
- R2: A read of `cfg_rdata` returns the bits 23:0 last written. Bits 31:24 always read as zero.
- R3: Field layout of the configuration word: bits 7:0 set the main ratio, bits 15:8 set the 10 µs ratio, and bits 23:16 set the 1 ms ratio. A field value v sets the ratio to v+1.
- R4: With main ratio N, `main_tick` goes high for one cycle once every N parent cycles.
- R5: With 10 µs ratio M, `us10_tick` fires on every M-th `main_tick` and in the same cycle as that main tick. It is never high without `main_tick`.
- R6: With 1 ms ratio P, `ms1_tick` fires on every P-th `main_tick`. It counts main ticks and not 10 µs ticks.
- R7: A write resets all counters. No tick is high in the write cycle. Counting the cycle after the write edge as cycle 1, the first `main_tick` comes in cycle N.
- R8: The largest main ratio, 256 (field value 255), gives one `main_tick` every 256 parent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| main_tick | output | 1 | Main conversion enable pulse |
| us10_tick | output | 1 | 10 µs interval pulse |
| ms1_tick | output | 1 | 1 ms interval pulse |

## Verification
The hardest case to reach is a separate 1 ms cascade. Choosing the same ratio for both slow stages hides a design that counts 10 µs ticks in place of main ticks. The bench therefore sets a main ratio above one and gives the two slow stages ratios whose products with the main ratio land on different cycles. It then compares every output against its expected value on every cycle of the window. The counter reload is exercised by writing in the middle of a period and checking that the first pulse is measured from the write and not from the old phase.

// File: rtl/adc_tick_pkg.sv
package adc_tick_pkg;
   localparam int unsigned NUM_STAGES = 3;
   typedef enum int unsigned {
      STG_MAIN = 0,
      STG_US10 = 1,
      STG_MS1  = 2
   } stage_e;
endpackage

// File: rtl/adc_tick_cfg.sv
module adc_tick_cfg #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned USED_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_W-1:0]  wdata,
   output logic [USED_W-1:0] q,
   output logic [REG_W-1:0]  rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata[USED_W-1:0];
   end

   generate
      if (REG_W > USED_W) begin : g_pad
         assign rdata = {{(REG_W-USED_W){1'b0}}, q};
      end else begin : g_full
         assign rdata = q;
      end
   endgenerate
endmodule

// File: rtl/adc_tick_stage.sv
module adc_tick_stage #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [CNT_W-1:0] limit,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt == limit);
   assign tick = en & ~clr & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (en)     cnt <= wrap ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
   import adc_tick_pkg::*;
#(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned FIELD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   output logic             main_tick,
   output logic             us10_tick,
   output logic             ms1_tick
);
   localparam int unsigned USED_W = FIELD_W * NUM_STAGES;

   generate
      if (USED_W > REG_W) begin : g_bad_width
         $error("adc_tick_gen: fields do not fit in the register");
      end
      if (FIELD_W < 1) begin : g_bad_field
         $error("adc_tick_gen: FIELD_W must be at least 1");
      end
   endgenerate

   logic [USED_W-1:0]     cfg_q;
   logic [NUM_STAGES-1:0] stg_en;
   logic [NUM_STAGES-1:0] stg_tick;

   adc_tick_cfg #(.REG_W(REG_W), .USED_W(USED_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (cfg_q),
      .rdata (cfg_rdata)
   );

   // Main stage counts parent cycles; every slower stage counts main enables.
   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
         if (i == STG_MAIN) begin : g_root
            assign stg_en[i] = 1'b1;
         end else begin : g_cascade
            assign stg_en[i] = stg_tick[STG_MAIN];
         end
         adc_tick_stage #(.CNT_W(FIELD_W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cfg_we),
            .en    (stg_en[i]),
            .limit (cfg_q[i*FIELD_W +: FIELD_W]),
            .tick  (stg_tick[i])
         );
      end
   endgenerate

   assign main_tick = stg_tick[STG_MAIN];
   assign us10_tick = stg_tick[STG_US10];
   assign ms1_tick  = stg_tick[STG_MS1];
endmodule

// File: rtl/adc_tick_chk.sv
module adc_tick_chk #(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned FIELD_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [REG_W-1:0] cfg_wdata,
   input logic [REG_W-1:0] cfg_rdata,
   input logic             main_tick,
   input logic             us10_tick,
   input logic             ms1_tick
);
   localparam int unsigned USED_W = FIELD_W * 3;

   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata >> USED_W) == '0);

   p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we) |-> cfg_rdata[USED_W-1:0] == $past(cfg_wdata[USED_W-1:0]));

   p_us10_with_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
      us10_tick |-> main_tick);

   p_ms1_with_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ms1_tick |-> main_tick);

   p_quiet_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> !(main_tick || us10_tick || ms1_tick));

   p_div1_every_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && cfg_rdata[FIELD_W-1:0] == '0) |-> main_tick);

   p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (main_tick && cfg_rdata[FIELD_W-1:0] != '0) |=> !main_tick);
endmodule

bind adc_tick_gen adc_tick_chk #(.REG_W(REG_W), .FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/adc_tick_gen_bench.sv
module adc_tick_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        main_tick, us10_tick, ms1_tick;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   adc_tick_gen u_adc_tick_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .main_tick(main_tick), .us10_tick(us10_tick),
      .ms1_tick(ms1_tick)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // R7: write strobe set, outputs sampled in the write cycle must be quiet.
   task automatic write_cfg(input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      #1;
      check(!(main_tick || us10_tick || ms1_tick), "R7", "ticks in write cycle",
            {main_tick, us10_tick, ms1_tick}, 0);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Observe cycles 1..ncyc after a write and compare every output per cycle.
   task automatic observe(input int n, input int m, input int p, input int ncyc,
                          input string req);
      int bad_m = 0, bad_u = 0, bad_s = 0;
      int first_m = 0;
      for (int k = 1; k <= ncyc; k++) begin
         #1;
         if (main_tick != (k % n == 0))       begin if (bad_m == 0) first_m = k; bad_m++; end
         if (us10_tick != (k % (n*m) == 0))   bad_u++;
         if (ms1_tick  != (k % (n*p) == 0))   bad_s++;
         @(negedge clk);
      end
      check(bad_m == 0, req, "main_tick mismatching cycles (first)", first_m, 0);
      check(bad_u == 0, req, "us10_tick mismatching cycles", bad_u, 0);
      check(bad_s == 0, req, "ms1_tick mismatching cycles", bad_s, 0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cfg_rdata == 32'h0, "R1", "rdata after reset", cfg_rdata, 0);
      observe(1, 1, 1, 5, "R1");
   endtask

   task automatic t_readback;
      write_cfg(32'hA5_3C_2B_1A);
      #1;
      check(cfg_rdata == 32'h00_3C_2B_1A, "R2", "readback", cfg_rdata, 32'h003C2B1A);
   endtask

   task automatic t_fields;
      // R3 R4 R5 R6: main 3, 10us 4, 1ms 6 -> 10us at 12, 1ms at 18
      write_cfg(32'h00_05_03_02);
      observe(3, 4, 6, 80, "R6");
      // main 1, 10us 5, 1ms 2
      write_cfg(32'h00_01_04_00);
      observe(1, 5, 2, 30, "R5");
      // main 5, 10us 1, 1ms 3
      write_cfg(32'h00_02_00_04);
      observe(5, 1, 3, 40, "R3");
   endtask

   task automatic t_reload;
      write_cfg(32'h00_01_01_09);
      repeat (4) @(negedge clk);
      // R7: rewrite mid-period; phase must restart from this write
      write_cfg(32'h00_01_01_09);
      observe(10, 2, 2, 45, "R7");
   endtask

   task automatic t_max;
      write_cfg(32'h00_00_01_FF);
      observe(256, 2, 1, 600, "R8");
   endtask

   initial begin
      t_reset;
      t_readback;
      t_fields;
      t_reload;
      t_max;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule